// File: doc/BRIEF.md
# Voltage Reference Slew Controller

This block turns an 8-bit voltage identification code into a reference code for a DAC and moves that reference toward the commanded target one 5 mV code at a time. A command strobe carries a command kind and a target code. The kind sets the pace of the walk. A fast set steps once every N clocks, where N comes from a programmable input. A slow set steps every 4N clocks. A decay set steps every 8N clocks, and it also pauses whenever a load-limited flag reports that the output has not yet caught up with the reference.

Alongside the code, the block drives the matching voltage in millivolts. It also drives a flag that is high while the reference sits on its target. A gain-boost flag is high while a fast command is still driving the voltage upward, so that a downstream error amplifier can answer more quickly during that move.

A command that arrives part-way through a walk takes effect at once. The walk continues from the reference value of that moment, toward the new target, at the new command's pace.

Top module: `vid_ref_slew`

## Requirements
- R1: After reset, the reference code is 0x00, the millivolt output is 0, settled is 1 and gain boost is 0.
- R2: The millivolt output is 0 for code 0x00, and 250 + 5*(code-1) for any other code, so 0x20 gives 405 and 0x42 gives 575.
- R3: `cmd_kind` 0 is a fast set. For a fast set, the first step lands N clock edges after the edge that accepts the command, and each later step lands N edges after the one before. A `fast_period` of 0 is treated as N=1.
- R4: `cmd_kind` 1 is a slow set. A slow set steps every 4N edges. `cmd_kind` 3 is handled the same as a slow set.
- R5: `cmd_kind` 2 is a decay set, which steps every 8N edges. On each edge where `load_lag` is 1 during a decay set, the interval count is frozen, so every remaining step moves later by one edge.
- R6: During a fast set or a slow set, `load_lag` has no effect on step timing.
- R7: An accepted command restarts the interval count from the present reference, using the new pace. If the command arrives on an edge where a step was due, no step is taken on that edge.
- R8: Settled is 1 exactly when the reference equals the target. Once settled, the reference stays put until the next command.
- R9: Gain boost is 1 exactly while the active command is a fast set and the target is above the reference.
- R10: Each step changes the reference by exactly one code. A target of 0x00 walks the reference down through 0x01 and then to 0x00, where the output reads 0 mV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_kind | input | 2 | 0 fast, 1 slow, 2 decay, 3 slow |
| cmd_vid | input | 8 | Target identification code |
| fast_period | input | IV_W | Fast step interval N, in clocks |
| load_lag | input | 1 | Output still behind the reference; pauses a decay walk |
| ref_code | output | 8 | Present reference DAC code |
| ref_mv | output | 11 | Present reference in millivolts |
| settled | output | 1 | Reference equals target |
| gain_boost | output | 1 | Fast upward move in progress |

## Verification
Two things can fall on the same clock edge: a new command being accepted and a step coming due from the previous command. The bench provokes this by waiting until the edge on which the second step of a fast walk is due and presenting a slow command on exactly that edge. The scoreboard expects three things. The reference keeps its value on that edge. The walk then continues from that value toward the new target. Its first step lands a full slow interval after the collision edge.

// File: rtl/vref_pkg.sv
package vref_pkg;

  localparam int VID_W = 8;
  localparam int MV_W  = 11;

  typedef enum logic [1:0] {
    CMD_FAST  = 2'd0,
    CMD_SLOW  = 2'd1,
    CMD_DECAY = 2'd2
  } slew_cmd_e;

  // Code 0 is off; code k>0 is 250 mV + 5 mV*(k-1) = 245 + 5k.
  function automatic logic [MV_W-1:0] vid_to_mv(input logic [VID_W-1:0] code);
    logic [MV_W-1:0] w;
    w = MV_W'(code);
    if (code == '0) return '0;
    return (w << 2) + w + MV_W'(245);
  endfunction

  // Folds the 2-bit command field onto the three paces.
  function automatic slew_cmd_e decode_cmd(input logic [1:0] raw);
    case (raw)
      2'd0:    return CMD_FAST;
      2'd2:    return CMD_DECAY;
      default: return CMD_SLOW;
    endcase
  endfunction

endpackage

// File: rtl/vref_interval.sv
module vref_interval
  import vref_pkg::*;
#(
  parameter int IV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            active,
  input  logic            freeze,
  input  slew_cmd_e       mode,
  input  logic [IV_W-1:0] n_fast,
  output logic            step_fire
);

  localparam int CW = IV_W + 3;

  function automatic logic [CW-1:0] interval_limit(input slew_cmd_e m,
                                                   input logic [IV_W-1:0] n);
    logic [CW-1:0] ne;
    ne = (n == '0) ? CW'(1) : CW'(n);
    case (m)
      CMD_FAST:  return ne;
      CMD_DECAY: return ne << 3;
      default:   return ne << 2;
    endcase
  endfunction

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          due;

  assign limit     = interval_limit(mode, n_fast);
  assign due       = (cnt_q >= limit - CW'(1));
  assign step_fire = active && !freeze && !restart && due;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || !active) cnt_q <= '0;
    else if (freeze)             cnt_q <= cnt_q;
    else if (step_fire)          cnt_q <= '0;
    else                         cnt_q <= cnt_q + CW'(1);
  end

  // R7: a command always restarts the interval count.
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R5: a frozen count neither advances nor fires.
  a_r5_freeze_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && active && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/vref_track.sv
module vref_track
  import vref_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [VID_W-1:0] cmd_vid,
  input  logic             step_fire,
  output logic [VID_W-1:0] ref_q,
  output slew_cmd_e        mode_q,
  output logic             active,
  output logic             settled,
  output logic             boost_req
);

  logic [VID_W-1:0] tgt_q;
  logic             going_up;

  assign going_up  = (tgt_q > ref_q);
  assign active    = (tgt_q != ref_q);
  assign settled   = !active;
  assign boost_req = (mode_q == CMD_FAST) && going_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      tgt_q  <= '0;
      mode_q <= CMD_FAST;
    end else if (cmd_valid) begin
      tgt_q  <= cmd_vid;
      mode_q <= decode_cmd(cmd_kind);
    end else if (step_fire) begin
      ref_q  <= going_up ? ref_q + 1'b1 : ref_q - 1'b1;
    end
  end

  // R10: the reference never moves by more than one code per edge.
  a_r10_single_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q == $past(ref_q)) || (ref_q == $past(ref_q) + 1'b1) ||
    (ref_q == $past(ref_q) - 1'b1));

  // R7: the command edge wins over a due step.
  a_r7_cmd_holds_ref: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> $stable(ref_q));

  // R8: once settled, the reference stays settled without a command.
  a_r8_settled_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !cmd_valid) |=> (settled && $stable(ref_q)));

endmodule

// File: rtl/vid_ref_slew.sv
module vid_ref_slew
  import vref_pkg::*;
#(
  parameter int IV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [VID_W-1:0] cmd_vid,
  input  logic [IV_W-1:0]  fast_period,
  input  logic             load_lag,
  output logic [VID_W-1:0] ref_code,
  output logic [MV_W-1:0]  ref_mv,
  output logic             settled,
  output logic             gain_boost
);

  slew_cmd_e mode;
  logic      active;
  logic      step_fire;
  logic      hold_decay;
  logic      boost_req;

  assign hold_decay = load_lag && (mode == CMD_DECAY);

  vref_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_vid   (cmd_vid),
    .step_fire (step_fire),
    .ref_q     (ref_code),
    .mode_q    (mode),
    .active    (active),
    .settled   (settled),
    .boost_req (boost_req)
  );

  vref_interval #(.IV_W(IV_W)) u_interval (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (cmd_valid),
    .active    (active),
    .freeze    (hold_decay),
    .mode      (mode),
    .n_fast    (fast_period),
    .step_fire (step_fire)
  );

  assign ref_mv     = vid_to_mv(ref_code);
  assign gain_boost = boost_req;

  // R9: boost never coexists with a settled reference.
  a_r9_no_boost_settled: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> !gain_boost);

  // R5: a held decay walk keeps the reference still.
  a_r5_decay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_decay |=> $stable(ref_code));

  // R2: code zero reads as zero millivolts.
  a_r2_zero_is_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code == '0) |-> (ref_mv == '0));

endmodule

// File: tb/vid_ref_slew_bench.sv
module vid_ref_slew_bench;
  import vref_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [7:0]  cmd_vid = 8'd0;
  logic [7:0]  fast_period = 8'd2;
  logic        load_lag = 1'b0;
  logic [7:0]  ref_code;
  logic [10:0] ref_mv;
  logic        settled;
  logic        gain_boost;

  always #5 clk = ~clk;

  vid_ref_slew u_vid_ref_slew (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_vid(cmd_vid), .fast_period(fast_period), .load_lag(load_lag),
    .ref_code(ref_code), .ref_mv(ref_mv), .settled(settled),
    .gain_boost(gain_boost)
  );

  typedef struct {
    int         at;
    logic [7:0] code;
    logic       st;
    logic       bst;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  int         cyc = 0;
  int         last_c = 0;
  logic [7:0] last_code = 8'd0;

  always @(posedge clk) cyc <= cyc + 1;

  // Millivolt value restated: base 250 for code 1, 5 mV per code after that.
  function automatic int mv_of(input logic [7:0] c);
    if (c == 8'd0) return 0;
    return 250 + 5 * (int'(c) - 1);
  endfunction

  task automatic cmp(input string tag, input logic [7:0] code,
                     input logic st, input logic bst);
    n_cmp++;
    if (ref_code !== code || int'(ref_mv) != mv_of(code) ||
        settled !== st || gain_boost !== bst) begin
      n_bad++;
      $display("FAIL %s cyc=%0d: code=%h mv=%0d st=%b bst=%b, expected code=%h mv=%0d st=%b bst=%b",
               tag, cyc, ref_code, ref_mv, settled, gain_boost, code, mv_of(code), st, bst);
    end
  endtask

  // Monitor: compare the head item on its cycle.
  always @(negedge clk) begin : mon
    exp_t e;
    if (sb.size() > 0 && sb[0].at < cyc) begin
      e = sb.pop_front();
      n_cmp++; n_bad++;
      $display("FAIL %s: item for cyc %0d missed (now %0d), expected code=%h",
               e.tag, e.at, cyc, e.code);
    end else if (sb.size() > 0 && sb[0].at == cyc) begin
      e = sb.pop_front();
      cmp(e.tag, e.code, e.st, e.bst);
      last_code = e.code;
    end
  end

  // Driver: called at a negedge; pushes the expected walk, then strobes.
  task automatic issue(input logic [1:0] t, input logic [7:0] v, input int n,
                       input int lag, input string tag);
    int c, nn, L, shift, d;
    logic [7:0] r;
    logic up;
    exp_t e;
    c = cyc + 1;
    last_c = c;
    for (int i = sb.size() - 1; i >= 0; i--) if (sb[i].at >= c) sb.delete(i);
    r = last_code;
    foreach (sb[i]) if (sb[i].at < c) r = sb[i].code;
    nn = (n == 0) ? 1 : n;
    L = (t == 2'd0) ? nn : (t == 2'd2) ? 8 * nn : 4 * nn;
    shift = (t == 2'd2) ? lag : 0;
    up = (v > r);
    d = up ? int'(v) - int'(r) : int'(r) - int'(v);
    e.tag = tag;
    e.at = c; e.code = r; e.st = (d == 0); e.bst = (t == 2'd0) && up;
    sb.push_back(e);
    for (int i = 1; i <= d; i++) begin
      e.at = c + shift + i * L;
      e.code = up ? r + 8'(i) : r - 8'(i);
      e.st = (i == d);
      e.bst = (t == 2'd0) && up && (i != d);
      sb.push_back(e);
    end
    e.at = c + shift + d * L + 2; e.code = v; e.st = 1'b1; e.bst = 1'b0;
    sb.push_back(e);
    cmd_valid = 1'b1; cmd_kind = t; cmd_vid = v;
    fast_period = 8'(n); load_lag = (lag > 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (lag > 0) begin
      repeat (lag) @(negedge clk);
      load_lag = 1'b0;
    end
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 reset", 8'h00, 1'b1, 1'b0);
    // R3 R9 R2: fast up from off, boost during the rise
    issue(2'd0, 8'h05, 2, 0, "R3 fast up");
    drain();
    // R4: slow up, no boost
    issue(2'd1, 8'h08, 2, 0, "R4 slow up");
    drain();
    // R5: decay down at 8N
    issue(2'd2, 8'h04, 2, 0, "R5 decay");
    drain();
    // R5: decay with load_lag freezing the count
    issue(2'd2, 8'h02, 1, 5, "R5 decay lag");
    drain();
    // R6: load_lag ignored in fast mode
    issue(2'd0, 8'h06, 2, 4, "R6 fast lag ignored");
    drain();
    // R6: load_lag ignored in slow mode
    issue(2'd1, 8'h04, 1, 3, "R6 slow lag ignored");
    drain();
    // R2 R3: fast to 0x20 (405 mV), N=1
    issue(2'd0, 8'h20, 1, 0, "R2 fast 0x20");
    drain();
    // R3: N=0 treated as 1, up to 0x42 (575 mV)
    issue(2'd0, 8'h42, 0, 0, "R3 N0 to 0x42");
    drain();
    // R7: command collides with the second due step
    issue(2'd0, 8'h30, 3, 0, "R7 fast down");
    while (cyc + 1 != last_c + 6) @(negedge clk);
    issue(2'd1, 8'h44, 1, 0, "R7 retarget slow");
    drain();
    // R8: re-issue the same target: settled, no movement
    issue(2'd0, 8'h44, 1, 0, "R8 same target");
    drain();
    // R10: walk to off through 0x01
    issue(2'd0, 8'h03, 1, 0, "R10 prep");
    drain();
    issue(2'd0, 8'h00, 2, 0, "R10 to zero");
    drain();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

endmodule